// File: doc/BRIEF.md
# Reset Source Controller with Pulse Stretching

This block merges five reset requests into one internal reset for the rest of the chip. The five are supply ramp-up, a filtered brownout, a software strobe, the external reset line and a watchdog strobe. It pulls an open-drain external reset line low so that outside devices are reset together with the core. It also senses that same line, so that a push-button or another device can start a reset. Each reset is stretched so that the external pulse lasts exactly 2^(N+1) slow-clock cycles, where N is a 4-bit stretch exponent sampled when the reset starts. If something outside keeps the line low for longer, the internal reset stays asserted until the line is seen high again.

The block is clocked by the always-running slow clock. The supply-good level acts as its asynchronous reset. While supply-good is low, everything is held in reset. Once it rises, a power-up sequence runs using a fixed exponent. A status field reports the cause of the most recent reset with these codes: 0 power-up, 1 watchdog, 2 software, 3 external line, 4 brownout.

A brownout counts only if the brownout flag is seen high on more than `BOD_FILT` consecutive clock edges, and only while the non-volatile brownout-reset enable is set. When several requests arrive on the same edge, the cause is chosen by a fixed priority.

Top module: `reset_source_ctrl`

## Requirements
- R1: While `porGood` is low, `coreRst` and `pinDriveLow` are 1 and `rstCause` is 0 (power-up). After `porGood` rises, the line drive lasts 2^(POR_EXP+1) cycles (8 by default).
- R2: For a reset started from idle, `pinDriveLow` is high for exactly 2^(N+1) cycles, where N is `stretchExp` at the start edge (N from 0 to 15).
- R3: `coreRst` rises together with `pinDriveLow`. It stays high for one settle cycle after the drive ends and then until the line is sensed high, which gives at least 2^(N+1)+2 cycles.
- R4: A brownout starts a reset only if `brownFlag` is high on `BOD_FILT`+1 consecutive edges. A shorter assertion has no effect and leaves `rstCause` unchanged.
- R5: While `brownRstEn` is 0, a brownout of any length starts no reset.
- R6: A one-cycle `wdtRstReq` starts a reset with cause 1.
- R7: A one-cycle `swRstReq` starts a reset with cause 2.
- R8: `extPinLevel` low while idle starts a reset with cause 3. If the line is held low for H cycles, `coreRst` stays high for max(2^(N+1)+2, H) cycles.
- R9: The low level that the block itself drives on the line is never taken as an external request. After a reset completes, no further reset follows and `rstCause` keeps its value.
- R10: Requests that arrive on the same edge are ranked: brownout, then watchdog, then software, then external line.
- R11: Requests that arrive during a reset sequence are ignored. They neither restart the sequence nor change `rstCause`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| porGood | input | 1 | Supply-good level; low holds the block in power-up reset |
| brownFlag | input | 1 | Raw brownout detector flag |
| brownRstEn | input | 1 | Non-volatile enable for brownout resets |
| swRstReq | input | 1 | Software reset strobe |
| wdtRstReq | input | 1 | Watchdog reset strobe |
| extPinLevel | input | 1 | Synchronised level of the external reset line (low = reset) |
| stretchExp | input | EXP_W | Stretch exponent N; pulse is 2^(N+1) cycles |
| coreRst | output | 1 | Internal reset, active high |
| pinDriveLow | output | 1 | Open-drain pull-down enable for the external line |
| rstCause | output | 3 | Cause of the last reset (0 pwr, 1 wdt, 2 sw, 3 line, 4 brownout) |

## Verification
Each source is fired on its own, with stretch exponents from 0 to 15, so that the pulse length and the recorded cause can be told apart per source. Coincident requests in mixed combinations separate the priority ranking from plain arrival order. Brownout pulses one edge short of the filter, and long pulses with the enable cleared, expose any leak past the filter or the gate. A line held low for longer than the minimum shows whether the release waits for the line. A strobe injected in mid-sequence, and the idle time after a self-driven pulse, show whether the block's own drive or late requests ever start a second reset.

// File: rtl/rst_src_pkg.sv
package rst_src_pkg;

  typedef enum logic [2:0] {
    CAUSE_POWERUP  = 3'd0,
    CAUSE_WATCHDOG = 3'd1,
    CAUSE_SOFTWARE = 3'd2,
    CAUSE_USER     = 3'd3,
    CAUSE_BROWNOUT = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRIVE,
    ST_SETTLE,
    ST_HOLD
  } seq_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   start;
    logic   counting;
    cause_e cause;
  } seq_ctl_t;

endpackage

// File: rtl/rst_src_datapath.sv
module rst_src_datapath
  import rst_src_pkg::*;
#(
  parameter int EXP_W    = 4,
  parameter int BOD_FILT = 4,
  parameter int POR_EXP  = 2
) (
  input  logic             clk,
  input  logic             porGood,
  input  logic             brownFlag,
  input  logic [EXP_W-1:0] stretchExp,
  input  seq_ctl_t         ctl,
  output logic             bodHit,
  output logic             stretchDone,
  output cause_e           causeOut
);

  localparam int CNT_W = (1 << EXP_W) + 1;
  localparam int BOD_W = $clog2(BOD_FILT + 1);
  localparam logic [BOD_W-1:0] BOD_MAX = BOD_W'(BOD_FILT);
  localparam logic [EXP_W-1:0] POR_N   = EXP_W'(POR_EXP);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [BOD_W-1:0] bodCnt;
  logic [CNT_W-1:0] stretchCnt;
  logic [EXP_W-1:0] expQ;
  logic [EXP_W:0]   shAmt;
  logic [CNT_W-1:0] limit;
  cause_e           causeQ;

  // brownout glitch filter: consecutive-high counter, saturating
  always_ff @(posedge clk or negedge porGood) begin
    if (!porGood)                bodCnt <= '0;
    else if (!brownFlag)         bodCnt <= '0;
    else if (bodCnt != BOD_MAX)  bodCnt <= bodCnt + 1'b1;
  end

  assign bodHit = brownFlag && (bodCnt == BOD_MAX);

  // pulse stretch counter and latched exponent / cause
  always_ff @(posedge clk or negedge porGood) begin
    if (!porGood) begin
      stretchCnt <= '0;
      expQ       <= POR_N;
      causeQ     <= CAUSE_POWERUP;
    end else if (ctl.start) begin
      stretchCnt <= '0;
      expQ       <= stretchExp;
      causeQ     <= ctl.cause;
    end else if (ctl.counting) begin
      stretchCnt <= stretchCnt + 1'b1;
    end
  end

  assign shAmt       = {1'b0, expQ} + (EXP_W+1)'(1);
  assign limit       = (ONE << shAmt) - ONE;
  assign stretchDone = (stretchCnt == limit);
  assign causeOut    = causeQ;

endmodule

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl
  import rst_src_pkg::*;
(
  input  logic     clk,
  input  logic     porGood,
  input  logic     bodHit,
  input  logic     brownRstEn,
  input  logic     wdtRstReq,
  input  logic     swRstReq,
  input  logic     extPinLevel,
  input  logic     stretchDone,
  output seq_ctl_t ctl,
  output logic     coreRst,
  output logic     pinDriveLow
);

  seq_state_e stateQ, stateD;
  logic       reqAny;
  cause_e     reqCause;

  // fixed-priority request encoder
  always_comb begin
    reqAny   = 1'b1;
    reqCause = CAUSE_USER;
    if (bodHit && brownRstEn) reqCause = CAUSE_BROWNOUT;
    else if (wdtRstReq)       reqCause = CAUSE_WATCHDOG;
    else if (swRstReq)        reqCause = CAUSE_SOFTWARE;
    else if (!extPinLevel)    reqCause = CAUSE_USER;
    else                      reqAny   = 1'b0;
  end

  // line is only sensed in idle, so self-driven lows never count
  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (reqAny)      stateD = ST_DRIVE;
      ST_DRIVE:  if (stretchDone) stateD = ST_SETTLE;
      ST_SETTLE:                  stateD = ST_HOLD;
      ST_HOLD:   if (extPinLevel) stateD = ST_IDLE;
      default:                    stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge porGood) begin
    if (!porGood) stateQ <= ST_DRIVE;
    else          stateQ <= stateD;
  end

  assign ctl.start    = (stateQ == ST_IDLE) && reqAny;
  assign ctl.counting = (stateQ == ST_DRIVE);
  assign ctl.cause    = reqCause;
  assign coreRst      = (stateQ != ST_IDLE);
  assign pinDriveLow  = (stateQ == ST_DRIVE);

endmodule

// File: rtl/reset_source_ctrl.sv
module reset_source_ctrl
  import rst_src_pkg::*;
#(
  parameter int EXP_W    = 4,
  parameter int BOD_FILT = 4,
  parameter int POR_EXP  = 2
) (
  input  logic             clk,
  input  logic             porGood,
  input  logic             brownFlag,
  input  logic             brownRstEn,
  input  logic             swRstReq,
  input  logic             wdtRstReq,
  input  logic             extPinLevel,
  input  logic [EXP_W-1:0] stretchExp,
  output logic             coreRst,
  output logic             pinDriveLow,
  output logic [2:0]       rstCause
);

  seq_ctl_t ctl;
  logic     bodHit;
  logic     stretchDone;
  cause_e   causeOut;

  rst_src_ctrl u_ctrl (
    .clk         (clk),
    .porGood     (porGood),
    .bodHit      (bodHit),
    .brownRstEn  (brownRstEn),
    .wdtRstReq   (wdtRstReq),
    .swRstReq    (swRstReq),
    .extPinLevel (extPinLevel),
    .stretchDone (stretchDone),
    .ctl         (ctl),
    .coreRst     (coreRst),
    .pinDriveLow (pinDriveLow)
  );

  rst_src_datapath #(
    .EXP_W    (EXP_W),
    .BOD_FILT (BOD_FILT),
    .POR_EXP  (POR_EXP)
  ) u_dp (
    .clk         (clk),
    .porGood     (porGood),
    .brownFlag   (brownFlag),
    .stretchExp  (stretchExp),
    .ctl         (ctl),
    .bodHit      (bodHit),
    .stretchDone (stretchDone),
    .causeOut    (causeOut)
  );

  assign rstCause = causeOut;

endmodule

// File: rtl/rst_src_chk.sv
module rst_src_chk #(
  parameter int EXP_W   = 4,
  parameter int POR_EXP = 2
) (
  input logic             clk,
  input logic             porGood,
  input logic             brownFlag,
  input logic             brownRstEn,
  input logic             extPinLevel,
  input logic [EXP_W-1:0] stretchExp,
  input logic             coreRst,
  input logic             pinDriveLow,
  input logic [2:0]       rstCause
);

  logic             seen;
  logic [EXP_W-1:0] expCap;
  logic [31:0]      drvLen;

  always_ff @(posedge clk or negedge porGood) begin
    if (!porGood) begin
      seen   <= 1'b0;
      expCap <= EXP_W'(POR_EXP);
      drvLen <= '0;
    end else begin
      seen <= 1'b1;
      if (!coreRst) expCap <= stretchExp;
      if (pinDriveLow) drvLen <= drvLen + 1;
      else             drvLen <= '0;
    end
  end

  p_drive_in_reset_r3: assert property (@(posedge clk) disable iff (!porGood)
    pinDriveLow |-> coreRst);

  p_rise_drives_r3: assert property (@(posedge clk) disable iff (!porGood)
    seen && $rose(coreRst) |-> pinDriveLow);

  p_pulse_len_r2: assert property (@(posedge clk) disable iff (!porGood)
    seen && $fell(pinDriveLow) |-> drvLen == (32'd2 << expCap));

  p_release_line_high_r8: assert property (@(posedge clk) disable iff (!porGood)
    seen && $fell(coreRst) |-> $past(extPinLevel));

  p_bod_gated_r5: assert property (@(posedge clk) disable iff (!porGood)
    seen && $rose(coreRst) && !$past(brownRstEn) |-> rstCause != 3'd4);

  p_bod_needs_flag_r4: assert property (@(posedge clk) disable iff (!porGood)
    seen && $rose(coreRst) && rstCause == 3'd4 |-> $past(brownFlag));

  p_cause_frozen_r11: assert property (@(posedge clk) disable iff (!porGood)
    seen && $past(coreRst) |-> $stable(rstCause));

endmodule

bind reset_source_ctrl rst_src_chk #(.EXP_W(EXP_W), .POR_EXP(POR_EXP)) u_chk (
  .clk         (clk),
  .porGood     (porGood),
  .brownFlag   (brownFlag),
  .brownRstEn  (brownRstEn),
  .extPinLevel (extPinLevel),
  .stretchExp  (stretchExp),
  .coreRst     (coreRst),
  .pinDriveLow (pinDriveLow),
  .rstCause    (rstCause)
);

// File: tb/reset_source_ctrl_tb.sv
module reset_source_ctrl_tb;

  localparam int EXP_W    = 4;
  localparam int BOD_FILT = 4;
  localparam int POR_EXP  = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             porGood, brownFlag, brownRstEn, swRstReq, wdtRstReq, userLow;
  logic [EXP_W-1:0] stretchExp;
  logic             coreRst, pinDriveLow;
  logic [2:0]       rstCause;
  logic             extPinLevel;

  // open-drain line: low if the block or the outside world pulls it
  assign extPinLevel = !(pinDriveLow || userLow);

  reset_source_ctrl #(.EXP_W(EXP_W), .BOD_FILT(BOD_FILT), .POR_EXP(POR_EXP)) u_dut (
    .clk(clk), .porGood(porGood), .brownFlag(brownFlag), .brownRstEn(brownRstEn),
    .swRstReq(swRstReq), .wdtRstReq(wdtRstReq), .extPinLevel(extPinLevel),
    .stretchExp(stretchExp), .coreRst(coreRst), .pinDriveLow(pinDriveLow),
    .rstCause(rstCause)
  );

  typedef struct {
    int    cause;
    int    drv;
    int    rl;
    string tag;
  } exp_t;

  exp_t sbq[$];
  int   nChk = 0;
  int   nFail = 0;
  bit   monOn = 0;
  bit   inSeq = 0;
  int   drvCnt = 0;
  int   rstCnt = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  // monitor: measures each sequence and pops the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (monOn) begin
        if (coreRst) begin
          if (!inSeq) begin
            inSeq  = 1;
            drvCnt = 0;
            rstCnt = 0;
          end
          rstCnt++;
          if (pinDriveLow) drvCnt++;
        end else if (inSeq) begin
          inSeq = 0;
          if (sbq.size() == 0) begin
            check(1'b0, "R11", "unexpected reset sequence", 1, 0);
          end else begin
            exp_t e;
            e = sbq.pop_front();
            check(int'(rstCause) == e.cause, e.tag, "cause", int'(rstCause), e.cause);
            check(drvCnt == e.drv, e.tag, "line drive cycles", drvCnt, e.drv);
            check(rstCnt == e.rl, e.tag, "core reset cycles", rstCnt, e.rl);
          end
        end
      end
    end
  end

  // driver: mask bit0 sw, bit1 wdt, bit2 line, bit3 brownout
  task automatic fire(input logic [3:0] mask, input int n, input int hold,
                      input bit inject, input string tag);
    exp_t e;
    int   len;
    len     = 2 << n;
    e.cause = mask[3] ? 4 : mask[1] ? 1 : mask[0] ? 2 : 3;
    e.drv   = len;
    e.rl    = (hold > len + 2) ? hold : len + 2;
    e.tag   = tag;
    sbq.push_back(e);
    @(negedge clk);
    stretchExp = EXP_W'(n);
    if (mask[3]) begin
      brownFlag = 1'b1;
      repeat (BOD_FILT) @(posedge clk);
      @(negedge clk);
    end
    swRstReq  = mask[0];
    wdtRstReq = mask[1];
    userLow   = mask[2];
    @(posedge clk);
    @(negedge clk);
    swRstReq  = 1'b0;
    wdtRstReq = 1'b0;
    brownFlag = 1'b0;
    if (mask[2]) begin
      if (hold > 1) begin
        repeat (hold - 1) @(posedge clk);
        @(negedge clk);
      end
      userLow = 1'b0;
    end
    if (inject) begin
      @(negedge clk);
      swRstReq = 1'b1;
      @(negedge clk);
      swRstReq = 1'b0;
    end
    while (coreRst) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL timeout: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int n;
    porGood = 0; brownFlag = 0; brownRstEn = 1; swRstReq = 0; wdtRstReq = 0;
    userLow = 0; stretchExp = '0;
    repeat (3) @(negedge clk);
    // R1: held in power-up reset
    check(coreRst == 1'b1, "R1", "coreRst during supply low", int'(coreRst), 1);
    check(pinDriveLow == 1'b1, "R1", "line drive during supply low", int'(pinDriveLow), 1);
    check(rstCause == 3'd0, "R1", "cause during supply low", int'(rstCause), 0);
    porGood = 1;
    n = 0;
    while (pinDriveLow && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check(n == (2 << POR_EXP), "R1", "power-up drive cycles", n, 2 << POR_EXP);
    check(coreRst == 1'b1, "R3", "settle cycle after drive", int'(coreRst), 1);
    repeat (2) @(negedge clk);
    check(coreRst == 1'b0, "R3", "release after settle", int'(coreRst), 0);
    check(rstCause == 3'd0, "R1", "cause after power-up", int'(rstCause), 0);
    monOn = 1;

    fire(4'b0010, 0, 1, 0, "R6");
    fire(4'b0001, 3, 1, 0, "R7");
    // R9: own drive must not retrigger
    repeat (10) @(negedge clk);
    check(coreRst == 1'b0, "R9", "no reset after self-driven pulse", int'(coreRst), 0);
    check(rstCause == 3'd2, "R9", "cause kept after self-driven pulse", int'(rstCause), 2);

    fire(4'b0100, 1, 1, 0, "R8");
    fire(4'b0100, 1, 20, 0, "R8");

    // R4: one edge short of the filter
    @(negedge clk);
    brownFlag = 1;
    repeat (BOD_FILT) @(posedge clk);
    @(negedge clk);
    brownFlag = 0;
    repeat (6) @(negedge clk);
    check(coreRst == 1'b0, "R4", "short brownout filtered", int'(coreRst), 0);
    check(rstCause == 3'd3, "R4", "cause after short brownout", int'(rstCause), 3);

    // R5: enable cleared
    brownRstEn = 0;
    brownFlag  = 1;
    repeat (BOD_FILT + 6) @(posedge clk);
    @(negedge clk);
    brownFlag = 0;
    repeat (4) @(negedge clk);
    check(coreRst == 1'b0, "R5", "gated brownout", int'(coreRst), 0);
    check(rstCause == 3'd3, "R5", "cause after gated brownout", int'(rstCause), 3);
    brownRstEn = 1;

    fire(4'b1000, 0, 1, 0, "R4");
    fire(4'b0011, 1, 1, 0, "R10");
    fire(4'b0101, 0, 1, 0, "R10");
    fire(4'b1111, 0, 1, 0, "R10");
    fire(4'b0010, 2, 1, 1, "R11");
    fire(4'b0001, 15, 1, 0, "R2");

    repeat (4) @(negedge clk);
    check(sbq.size() == 0, "R2", "pending scoreboard items", sbq.size(), 0);
    summary();
    $finish;
  end

endmodule